// File: doc/BRIEF.md
# Stereo Audio Sample Buffer with Status Flags

This block sits between a host that moves compressed audio and an engine that plays or records it. It stores 4-bit sample nibbles in first-in, first-out order. In mono operation there is one buffer. In stereo operation the same storage is split into a left buffer and a right buffer, and each buffer keeps its own read and write positions. The total storage is chosen at run time as 256, 512 or 1024 bits.

Three status outputs report the buffer that `flag_ch_sel` selects: empty, more-than-half-full and full. The polarity of each output is set by a small command port. During playback, a one-cycle start pulse fires when the left (or mono) buffer first fills past its half mark, so the engine can start synthesis once enough data is queued. Whenever the capacity or the mono/stereo setting changes, the block clears both buffers.

Top module: `sfifo_stereo_buf`

## Requirements
- R1: After reset the block runs in 64-nibble mono, with both buffers empty. `empty_o` is 1, `mid_o` and `full_o` are 0, `rd_data` is 0 and `synth_start` is 0. All three polarity bits are 0, which means active high.
- R2: Each buffer holds a set number of nibbles. In mono, `cfg_cap` 0 gives 64 nibbles, 1 gives 128 nibbles, and 2 or 3 give 256 nibbles. In stereo each of the two buffers holds half that number.
- R3: Reads return nibbles in the order they were written, separately for each buffer. An accepted read updates `rd_data` one clock after the edge that accepts it.
- R4: `full_o` reports that the selected buffer holds its capacity. While a buffer is full, a write to it is dropped and its contents do not change.
- R5: `empty_o` reports that the selected buffer holds nothing. A read of an empty buffer leaves `rd_data` unchanged and does not move that buffer's read position.
- R6: `mid_o` reports that the selected buffer holds more than half its capacity.
- R7: When `play_mode` is 1, `synth_start` is high for exactly one cycle after the edge at which the left or mono buffer's fill moves from at most half to above half. When `play_mode` is 0 it stays low.
- R8: A cycle with `pol_we` high loads `pol_lo`. Bit 0 controls empty, bit 1 controls mid and bit 2 controls full. A bit of 1 makes that flag active low, and the setting applies from the next cycle.
- R9: In stereo, `wr_ch` and `rd_ch` choose the buffer (0 left, 1 right). The flags report the right buffer when `flag_ch_sel` is 1 and the left buffer when it is 0.
- R10: In mono, `wr_ch`, `rd_ch` and `flag_ch_sel` have no effect. Every access and every flag uses the single buffer.
- R11: An edge at which `cfg_cap` or `cfg_stereo` differs from the stored setting stores the new setting and empties both buffers. It also clears `rd_data` and `synth_start` and drops any read or write in that cycle. The polarity setting is kept.
- R12: A read and a write in the same cycle are both decided on the fill before that edge. A full buffer can be read and refused the write in the same cycle. An empty buffer takes the write and ignores the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cap | input | 2 | Capacity code |
| cfg_stereo | input | 1 | 1 = two channel buffers, 0 = one buffer |
| play_mode | input | 1 | 1 while playing back; enables the start pulse |
| pol_we | input | 1 | Loads the polarity setting |
| pol_lo | input | 3 | Polarity bits (empty, mid, full), 1 = active low |
| wr_en | input | 1 | Write request |
| wr_ch | input | 1 | Write channel in stereo |
| wr_data | input | 4 | Nibble to store |
| rd_en | input | 1 | Read request |
| rd_ch | input | 1 | Read channel in stereo |
| rd_data | output | 4 | Last nibble read |
| flag_ch_sel | input | 1 | Channel whose status the flags show |
| empty_o | output | 1 | Empty flag |
| mid_o | output | 1 | Above-half flag |
| full_o | output | 1 | Full flag |
| synth_start | output | 1 | One-cycle playback start pulse |

## Verification
The hardest state to reach is a setting change that arrives while both stereo buffers are partly filled and one of them is full. Reaching that state takes more than a hundred accepted writes to one channel, while reads and writes on the other channel keep it at an odd level, before the capacity code changes. The stimulus fills each channel on purpose, switches the flag selector between the two to check both levels, and then changes the setting. A long random phase then mixes write-heavy and read-heavy stretches with rare setting and polarity changes. This keeps the fill levels sweeping across the half and full marks.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        CAP_SMALL  = 2'd0,
        CAP_MEDIUM = 2'd1,
        CAP_LARGE  = 2'd2,
        CAP_ALIAS  = 2'd3
    } cap_code_e;

    localparam int POL_EMPTY_BIT = 0;
    localparam int POL_MID_BIT   = 1;
    localparam int POL_FULL_BIT  = 2;
    localparam int POL_W         = 3;

endpackage

// File: rtl/sfifo_depth_dec.sv
module sfifo_depth_dec
    import sfifo_pkg::*;
#(
    parameter int MAX_NIB = 256,
    parameter int CNT_W   = 9
) (
    input  logic [1:0]       cap,
    input  logic             stereo,
    output logic [CNT_W-1:0] depth_ch,
    output logic [CNT_W-1:0] half_ch
);
    localparam int MIN_NIB = MAX_NIB / 4;

    logic [1:0]       shift_amt;
    logic [CNT_W-1:0] base_nib;

    always_comb begin
        shift_amt = (cap == CAP_ALIAS) ? 2'(CAP_LARGE) : cap;
        base_nib  = CNT_W'(MIN_NIB) << shift_amt;
        depth_ch  = stereo ? (base_nib >> 1) : base_nib;
        half_ch   = depth_ch >> 1;
    end
endmodule

// File: rtl/sfifo_nib_ram.sv
module sfifo_nib_ram #(
    parameter int NIB_W = 4,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [NIB_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NIB_W-1:0] rdata
);
    logic [NIB_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sfifo_flag_mux.sv
module sfifo_flag_mux
    import sfifo_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [1:0][CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0]      depth_ch,
    input  logic [CNT_W-1:0]      half_ch,
    input  logic                  stereo,
    input  logic                  ch_sel,
    input  logic [POL_W-1:0]      pol,
    output logic                  empty_o,
    output logic                  mid_o,
    output logic                  full_o
);
    logic [1:0] raw_empty, raw_mid, raw_full;
    logic       sel;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        assign raw_empty[c] = (cnt[c] == '0);
        assign raw_mid[c]   = (cnt[c] > half_ch);
        assign raw_full[c]  = (cnt[c] == depth_ch);
    end

    always_comb begin
        sel     = stereo & ch_sel;
        empty_o = raw_empty[sel] ^ pol[POL_EMPTY_BIT];
        mid_o   = raw_mid[sel]   ^ pol[POL_MID_BIT];
        full_o  = raw_full[sel]  ^ pol[POL_FULL_BIT];
    end
endmodule

// File: rtl/sfifo_stereo_buf.sv
module sfifo_stereo_buf
    import sfifo_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int MAX_BITS = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_cap,
    input  logic             cfg_stereo,
    input  logic             play_mode,
    input  logic             pol_we,
    input  logic [2:0]       pol_lo,
    input  logic             wr_en,
    input  logic             wr_ch,
    input  logic [NIB_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_ch,
    output logic [NIB_W-1:0] rd_data,
    input  logic             flag_ch_sel,
    output logic             empty_o,
    output logic             mid_o,
    output logic             full_o,
    output logic             synth_start
);
    localparam int MAX_NIB = MAX_BITS / NIB_W;
    localparam int PTR_W   = $clog2(MAX_NIB);
    localparam int CNT_W   = PTR_W + 1;

    typedef struct packed {
        logic [1:0]               cap;
        logic                     stereo;
        logic [POL_W-1:0]         pol;
        logic [1:0][PTR_W-1:0]    wp;
        logic [1:0][PTR_W-1:0]    rp;
        logic [1:0][CNT_W-1:0]    cnt;
        logic [NIB_W-1:0]         rdat;
        logic                     synth;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] depth_ch, half_ch;
    logic             cfg_chg;
    logic [1:0]       wr_go, rd_go;
    logic             wsel, rsel;
    logic             mem_we;
    logic [PTR_W-1:0] mem_waddr, mem_raddr;
    logic [NIB_W-1:0] mem_rdata;
    logic [CNT_W-1:0] cnt_l, cnt_r;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p,
                                                 input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] s;
        s = {1'b0, p} + CNT_W'(1);
        return (s == lim) ? '0 : s[PTR_W-1:0];
    endfunction

    function automatic logic [PTR_W-1:0] phys(input logic st, input logic ch,
                                              input logic [PTR_W-1:0] p);
        return st ? {ch, p[PTR_W-2:0]} : p;
    endfunction

    sfifo_depth_dec #(.MAX_NIB(MAX_NIB), .CNT_W(CNT_W)) u_depth (
        .cap      (st_q.cap),
        .stereo   (st_q.stereo),
        .depth_ch (depth_ch),
        .half_ch  (half_ch)
    );

    sfifo_nib_ram #(.NIB_W(NIB_W), .DEPTH(MAX_NIB), .AW(PTR_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    sfifo_flag_mux #(.CNT_W(CNT_W)) u_flags (
        .cnt      (st_q.cnt),
        .depth_ch (depth_ch),
        .half_ch  (half_ch),
        .stereo   (st_q.stereo),
        .ch_sel   (flag_ch_sel),
        .pol      (st_q.pol),
        .empty_o  (empty_o),
        .mid_o    (mid_o),
        .full_o   (full_o)
    );

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        cfg_chg   = (cfg_cap != st_q.cap) || (cfg_stereo != st_q.stereo);
        wsel      = st_q.stereo & wr_ch;
        rsel      = st_q.stereo & rd_ch;
        wr_go     = '0;
        rd_go     = '0;
        mem_waddr = phys(st_q.stereo, wsel, st_q.wp[wsel]);
        mem_raddr = phys(st_q.stereo, rsel, st_q.rp[rsel]);

        if (pol_we) st_d.pol = pol_lo;

        if (cfg_chg) begin
            st_d.cap    = cfg_cap;
            st_d.stereo = cfg_stereo;
            st_d.wp     = '0;
            st_d.rp     = '0;
            st_d.cnt    = '0;
            st_d.rdat   = '0;
            st_d.synth  = 1'b0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                wr_go[c] = wr_en && (wsel == c[0]) && (st_q.cnt[c] != depth_ch);
                rd_go[c] = rd_en && (rsel == c[0]) && (st_q.cnt[c] != '0);
                if (wr_go[c]) st_d.wp[c] = ptr_inc(st_q.wp[c], depth_ch);
                if (rd_go[c]) st_d.rp[c] = ptr_inc(st_q.rp[c], depth_ch);
                st_d.cnt[c] = st_q.cnt[c] + CNT_W'(wr_go[c]) - CNT_W'(rd_go[c]);
            end
            if (|rd_go) st_d.rdat = mem_rdata;
            st_d.synth = play_mode && (st_d.cnt[0] > half_ch) && !(st_q.cnt[0] > half_ch);
        end
        mem_we = |wr_go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data     = st_q.rdat;
    assign synth_start = st_q.synth;
    assign cnt_l       = st_q.cnt[0];
    assign cnt_r       = st_q.cnt[1];
endmodule

module sfifo_stereo_buf_chk #(
    parameter int NIB_W = 4,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_l,
    input logic [CNT_W-1:0] cnt_r,
    input logic [CNT_W-1:0] depth_ch,
    input logic             cfg_chg,
    input logic [1:0]       rd_go,
    input logic             stereo_q,
    input logic [NIB_W-1:0] rd_data,
    input logic             synth_start
);
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_l <= depth_ch) && (cnt_r <= depth_ch));

    assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_l == depth_ch && !rd_go[0] && !cfg_chg) |=> (cnt_l == depth_ch));

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go == 2'b00 && !cfg_chg) |=> $stable(rd_data));

    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        synth_start |=> !synth_start);

    assert_mono_right_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !stereo_q |-> (cnt_r == '0));

    assert_cfg_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (cnt_l == '0 && cnt_r == '0 && rd_data == '0));
endmodule

bind sfifo_stereo_buf sfifo_stereo_buf_chk #(.NIB_W(NIB_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_l       (cnt_l),
    .cnt_r       (cnt_r),
    .depth_ch    (depth_ch),
    .cfg_chg     (cfg_chg),
    .rd_go       (rd_go),
    .stereo_q    (st_q.stereo),
    .rd_data     (rd_data),
    .synth_start (synth_start)
);

// File: tb/sfifo_stereo_buf_test.sv
module sfifo_stereo_buf_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_cap = 2'd0;
    logic       cfg_stereo = 1'b0;
    logic       play_mode = 1'b0;
    logic       pol_we = 1'b0;
    logic [2:0] pol_lo = 3'd0;
    logic       wr_en = 1'b0, wr_ch = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       rd_en = 1'b0, rd_ch = 1'b0;
    logic [3:0] rd_data;
    logic       flag_ch_sel = 1'b0;
    logic       empty_o, mid_o, full_o, synth_start;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [3:0] q0[$];
    logic [3:0] q1[$];
    logic [1:0] m_cap = 2'd0;
    logic       m_st = 1'b0;
    logic [2:0] m_pol = 3'd0;
    logic [3:0] m_rd = 4'd0;
    logic       m_syn = 1'b0;

    // bench-side settings applied at the next step
    logic [1:0] b_cap = 2'd0;
    logic       b_st = 1'b0;
    logic       b_play = 1'b0;
    logic       b_polwe = 1'b0;
    logic [2:0] b_polv = 3'd0;

    sfifo_stereo_buf uut (
        .clk(clk), .rst_n(rst_n), .cfg_cap(cfg_cap), .cfg_stereo(cfg_stereo),
        .play_mode(play_mode), .pol_we(pol_we), .pol_lo(pol_lo),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
        .flag_ch_sel(flag_ch_sel), .empty_o(empty_o), .mid_o(mid_o),
        .full_o(full_o), .synth_start(synth_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int depth_of(input logic [1:0] cap, input logic st);
        int d;
        d = 64 << ((cap == 2'd3) ? 2 : int'(cap));
        return st ? d / 2 : d;
    endfunction

    task automatic cmp1(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
        end
    endtask

    // compare every output against the model
    task automatic check_all();
        int dep, sz;
        dep = depth_of(m_cap, m_st);
        sz  = (m_st && flag_ch_sel) ? q1.size() : q0.size();
        cmp1("R5", "empty_o", empty_o, (sz == 0) ^ m_pol[0]);
        cmp1("R6", "mid_o", mid_o, (sz > dep / 2) ^ m_pol[1]);
        cmp1("R4", "full_o", full_o, (sz == dep) ^ m_pol[2]);
        cmp1("R7", "synth_start", synth_start, m_syn);
        n_cmp++;
        if (rd_data !== m_rd) begin
            n_bad++;
            $display("FAIL R3 rd_data at %0t: actual %h expected %h", $time, rd_data, m_rd);
        end
    endtask

    task automatic step(input logic we, input logic wc, input logic [3:0] wd,
                        input logic re, input logic rc, input logic cs);
        int dep, half, pre, s0, s1;
        bit wok, rok;
        logic wch, rch;
        wr_en = we; wr_ch = wc; wr_data = wd;
        rd_en = re; rd_ch = rc; flag_ch_sel = cs;
        cfg_cap = b_cap; cfg_stereo = b_st; play_mode = b_play;
        pol_we = b_polwe; pol_lo = b_polv;
        if (b_polwe) m_pol = b_polv;
        if (b_cap != m_cap || b_st != m_st) begin
            // R11: setting change empties everything
            q0.delete(); q1.delete();
            m_rd = 4'd0; m_syn = 1'b0; m_cap = b_cap; m_st = b_st;
        end else begin
            dep  = depth_of(m_cap, m_st);
            half = dep / 2;
            wch  = m_st & wc;   // R10: channel ignored in mono
            rch  = m_st & rc;
            s0 = q0.size(); s1 = q1.size();
            pre = s0;
            // R12: both decisions use the fill before the edge
            rok = re && (rch ? (s1 > 0) : (s0 > 0));
            wok = we && (wch ? (s1 < dep) : (s0 < dep));
            if (rok) m_rd = rch ? q1.pop_front() : q0.pop_front();
            if (wok) begin
                if (wch) q1.push_back(wd); else q0.push_back(wd);
            end
            m_syn = b_play && (q0.size() > half) && !(pre > half);
        end
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input int n, input logic cs);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0, cs);
    endtask

    task automatic set_pol(input logic [2:0] v);
        b_polwe = 1'b1; b_polv = v;
        step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0, flag_ch_sel);
        b_polwe = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: actual hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2 R4 R6 R7 R10: mono 64 nibbles, channel inputs toggled
        b_play = 1'b1;
        for (int i = 0; i < 66; i++) step(1'b1, i[0], 4'(i * 3 + 1), 1'b0, 1'b0, i[1]);
        // R12: full buffer, read and write together
        step(1'b1, 1'b0, 4'hA, 1'b1, 1'b1, 1'b1);
        // R3 R5: drain past empty
        for (int i = 0; i < 68; i++) step(1'b0, 1'b0, 4'd0, 1'b1, i[0], 1'b0);
        // R12: empty buffer, read and write together
        step(1'b1, 1'b0, 4'h5, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0);

        // R8: polarity changes
        set_pol(3'b111);
        idle(2, 1'b0);
        set_pol(3'b010);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 4'(i), 1'b0, 1'b0, 1'b0);
        set_pol(3'b000);

        // R11: change to stereo, largest capacity
        b_st = 1'b1; b_cap = 2'd2;
        idle(2, 1'b0);
        // R9: fill right to full, left past half
        for (int i = 0; i < 130; i++) step(1'b1, 1'b1, 4'(i ^ 5), 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 4'(i + 7), 1'b0, 1'b0, i[2]);
        idle(2, 1'b0);
        idle(2, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, i[0], 4'(i), 1'b1, ~i[0], i[1]);
        // R11: setting change with both buffers loaded
        b_cap = 2'd1;
        idle(1, 1'b1);
        idle(2, 1'b0);

        // R2: code 3 in mono gives 256 nibbles
        b_st = 1'b0; b_cap = 2'd3;
        idle(1, 1'b0);
        for (int i = 0; i < 258; i++) step(1'b1, 1'b0, 4'(i * 7), 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0);

        // random mix
        b_play = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            int bias;
            bias = ((i / 300) % 2 == 0) ? 75 : 25;
            if ($urandom_range(0, 299) == 0) begin
                b_cap = 2'($urandom_range(0, 3));
                b_st  = 1'($urandom_range(0, 1));
            end
            b_play = ((i / 500) % 2 == 1);
            if ($urandom_range(0, 149) == 0) begin
                b_polwe = 1'b1; b_polv = 3'($urandom_range(0, 7));
            end
            step($urandom_range(0, 99) < bias, 1'($urandom_range(0, 1)),
                 4'($urandom_range(0, 15)),
                 $urandom_range(0, 99) < (100 - bias), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)));
            b_polwe = 1'b0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule